// File: doc/BRIEF.md
# Transmit Gap Code Replacer

This block sits on the transmit path of a four-lane 10G media-independent interface, just ahead of the 8b/10b encoder. Each clock it takes one column: one byte and one control flag for each lane. Lane 0 carries the lowest byte. Inside the inter-packet gap it replaces idle characters with the ordered codes a link partner needs for lane deskew, byte synchronization and clock tolerance compensation. It passes every other byte through unchanged, one clock later.

A packet may only start on lane 0, but a packet can end on any lane. The gap can therefore begin part way through a column. Idle bytes that share a column with the terminate character become sync codes immediately. Every column that is idle on all lanes gets one replacement code, the same on all four lanes, taken from a short repeating schedule. A mode input turns the replacement off. With the mode off, the block is a plain one-cycle register.

Top module: `txgap_replacer`

## Requirements
- R1: While reset is asserted, and in the first output cycle after it, `tx_data_o` and `tx_ctrl_o` are all zero.
- R2: Output is registered with one clock of latency. With `xcvr_en` high, a lane byte that is not an idle (idle = control flag 1 with byte 0x07) is output unchanged, with its control flag. This covers data, start 0xFB on lane 0, terminate 0xFD and other control codes.
- R3: With `xcvr_en` low, every column is output unchanged. The gap schedule neither advances nor restarts.
- R4: With `xcvr_en` high, in a column holding a terminate (control flag 1, byte 0xFD) on any lane, each idle lane is output as /K/ 0xBC with control flag 1. The terminate also restarts the gap schedule.
- R5: The first all-idle column after a terminate, or after reset, is output as /K/ on every lane.
- R6: Number the all-idle columns since the last terminate (or reset) from g = 0. For g > 0, a column is output as /A/ 0x7C when g is a multiple of 16. Otherwise it is /R/ 0x1C when g is odd and /K/ 0xBC when g is even.
- R7: An all-idle column, with `xcvr_en` high, is output with control flags 1111 and the same code on all four lanes.
- R8: A column with idles on some lanes but no terminate is output unchanged, including its idles.
- R9: Columns that are neither all-idle nor hold a terminate leave the gap count g unchanged. The numbering continues across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xcvr_en | input | 1 | Enables idle replacement (transceiver mode) |
| tx_data_i | input | 32 | Input column, lane i in bits 8i+7:8i |
| tx_ctrl_i | input | 4 | Input control flags, bit i for lane i |
| tx_data_o | output | 32 | Output column, one clock later |
| tx_ctrl_o | output | 4 | Output control flags, one clock later |

## Verification
Every output depends only on the column presented at the previous rising edge and on the gap count built up from earlier columns. Each result is therefore due exactly one clock after its column. The bench drives a column on a falling edge and compares the output at the following falling edge against an expected value it computed when it drove that column. The gap count is kept in the bench as an unbounded integer, and the code is derived from it with modulo arithmetic, so the rollover of the schedule at g = 16 and g = 32 is checked independently of the design's wrapping counter.

// File: rtl/txgap_pkg.sv
package txgap_pkg;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_SYNC  = 8'hBC;
  localparam logic [7:0] CH_ALIGN = 8'h7C;
  localparam logic [7:0] CH_SKIP  = 8'h1C;

  typedef enum logic [1:0] {SYM_K = 2'd0, SYM_R = 2'd1, SYM_A = 2'd2} gap_sym_e;

  function automatic logic is_idle(input logic [7:0] b, input logic c);
    return c && (b == CH_IDLE);
  endfunction

  function automatic logic is_term(input logic [7:0] b, input logic c);
    return c && (b == CH_TERM);
  endfunction

  // first: column directly after terminate/reset; idx: position in schedule
  function automatic gap_sym_e pick_sym(input logic first, input logic [15:0] idx);
    if (first)           return SYM_K;
    else if (idx == '0)  return SYM_A;
    else if (idx[0])     return SYM_R;
    else                 return SYM_K;
  endfunction

  function automatic logic [7:0] sym_byte(input gap_sym_e s);
    case (s)
      SYM_A:   return CH_ALIGN;
      SYM_R:   return CH_SKIP;
      default: return CH_SYNC;
    endcase
  endfunction

endpackage

// File: rtl/txgap_classify.sv
module txgap_classify #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] data_i,
  input  logic [LANES-1:0]   ctrl_i,
  output logic [LANES-1:0]   lane_idle_o,
  output logic               full_idle_o,
  output logic               term_col_o
);
  import txgap_pkg::*;

  logic [LANES-1:0] lane_term;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_idle_o[i] = is_idle(data_i[8*i +: 8], ctrl_i[i]);
    assign lane_term[i]   = is_term(data_i[8*i +: 8], ctrl_i[i]);
  end

  assign full_idle_o = &lane_idle_o;
  assign term_col_o  = |lane_term;

endmodule

// File: rtl/txgap_sequencer.sv
module txgap_sequencer #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic term_col_i,
  input  logic full_idle_i,
  output txgap_pkg::gap_sym_e sym_o
);
  import txgap_pkg::*;

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          first_q;
  logic [CW-1:0] cnt_q;

  assign sym_o = pick_sym(first_q, 16'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      cnt_q   <= '0;
    end else if (en_i) begin
      if (term_col_i) begin
        first_q <= 1'b1;
        cnt_q   <= '0;
      end else if (full_idle_i) begin
        first_q <= 1'b0;
        cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/txgap_lane_sub.sv
module txgap_lane_sub (
  input  logic       en_i,
  input  logic [7:0] byte_i,
  input  logic       ctrl_i,
  input  logic       idle_i,
  input  logic       term_col_i,
  input  logic       full_idle_i,
  input  logic [7:0] gap_byte_i,
  output logic [7:0] byte_o,
  output logic       ctrl_o
);
  import txgap_pkg::*;

  always_comb begin
    byte_o = byte_i;
    ctrl_o = ctrl_i;
    if (en_i && idle_i) begin
      if (term_col_i) begin
        byte_o = CH_SYNC;
        ctrl_o = 1'b1;
      end else if (full_idle_i) begin
        byte_o = gap_byte_i;
        ctrl_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/txgap_replacer.sv
module txgap_replacer #(
  parameter int LANES      = 4,
  parameter int GAP_PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xcvr_en,
  input  logic [LANES*8-1:0] tx_data_i,
  input  logic [LANES-1:0]   tx_ctrl_i,
  output logic [LANES*8-1:0] tx_data_o,
  output logic [LANES-1:0]   tx_ctrl_o
);
  import txgap_pkg::*;

  localparam int DW = LANES * 8;

  logic [LANES-1:0] lane_idle;
  logic             full_idle;
  logic             term_col;
  gap_sym_e         gap_sym;
  logic [7:0]       gap_byte;
  logic [DW-1:0]    nxt_data;
  logic [LANES-1:0] nxt_ctrl;

  txgap_classify #(.LANES(LANES)) u_classify (
    .data_i      (tx_data_i),
    .ctrl_i      (tx_ctrl_i),
    .lane_idle_o (lane_idle),
    .full_idle_o (full_idle),
    .term_col_o  (term_col)
  );

  txgap_sequencer #(.PERIOD(GAP_PERIOD)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (xcvr_en),
    .term_col_i  (term_col),
    .full_idle_i (full_idle),
    .sym_o       (gap_sym)
  );

  assign gap_byte = sym_byte(gap_sym);

  for (genvar i = 0; i < LANES; i++) begin : g_sub
    txgap_lane_sub u_sub (
      .en_i        (xcvr_en),
      .byte_i      (tx_data_i[8*i +: 8]),
      .ctrl_i      (tx_ctrl_i[i]),
      .idle_i      (lane_idle[i]),
      .term_col_i  (term_col),
      .full_idle_i (full_idle),
      .gap_byte_i  (gap_byte),
      .byte_o      (nxt_data[8*i +: 8]),
      .ctrl_o      (nxt_ctrl[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data_o <= '0;
      tx_ctrl_o <= '0;
    end else begin
      tx_data_o <= nxt_data;
      tx_ctrl_o <= nxt_ctrl;
    end
  end

endmodule

// File: rtl/txgap_replacer_chk.sv
module txgap_replacer_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               xcvr_en,
  input logic [LANES*8-1:0] tx_data_i,
  input logic [LANES-1:0]   tx_ctrl_i,
  input logic [LANES*8-1:0] tx_data_o,
  input logic [LANES-1:0]   tx_ctrl_o,
  input logic [LANES-1:0]   lane_idle,
  input logic               full_idle,
  input logic               term_col
);
  import txgap_pkg::*;

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_en |=> (tx_data_o == $past(tx_data_i)) && (tx_ctrl_o == $past(tx_ctrl_i)));

  assert_partial_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_en && !full_idle && !term_col) |=>
      (tx_data_o == $past(tx_data_i)) && (tx_ctrl_o == $past(tx_ctrl_i)));

  assert_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_en && full_idle) |=>
      (tx_ctrl_o == '1) && (tx_data_o == {LANES{tx_data_o[7:0]}}));

  assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_en && full_idle) |=>
      (tx_data_o[7:0] == CH_SYNC || tx_data_o[7:0] == CH_ALIGN || tx_data_o[7:0] == CH_SKIP));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xcvr_en && !lane_idle[i]) |=>
        (tx_data_o[8*i +: 8] == $past(tx_data_i[8*i +: 8])) && (tx_ctrl_o[i] == $past(tx_ctrl_i[i])));

    assert_term_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xcvr_en && term_col && lane_idle[i]) |=>
        (tx_data_o[8*i +: 8] == CH_SYNC) && tx_ctrl_o[i]);
  end

endmodule

bind txgap_replacer txgap_replacer_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xcvr_en   (xcvr_en),
  .tx_data_i (tx_data_i),
  .tx_ctrl_i (tx_ctrl_i),
  .tx_data_o (tx_data_o),
  .tx_ctrl_o (tx_ctrl_o),
  .lane_idle (lane_idle),
  .full_idle (full_idle),
  .term_col  (term_col)
);

// File: tb/test_txgap_replacer.sv
module test_txgap_replacer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xcvr_en = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic [3:0]  tx_ctrl_i = '0;
  logic [31:0] tx_data_o;
  logic [3:0]  tx_ctrl_o;

  int tests = 0;
  int fails = 0;
  int gidx  = 0;
  bit has_prev = 0;
  logic [31:0] exp_d;
  logic [3:0]  exp_c;
  string exp_req;

  localparam logic [31:0] IDLE4 = 32'h07070707;

  always #10ns clk = ~clk;

  txgap_replacer i_txgap_replacer (
    .clk(clk), .rst_n(rst_n), .xcvr_en(xcvr_en),
    .tx_data_i(tx_data_i), .tx_ctrl_i(tx_ctrl_i),
    .tx_data_o(tx_data_o), .tx_ctrl_o(tx_ctrl_o)
  );

  task automatic check(input string req, input logic [31:0] ad, input logic [3:0] ac,
                       input logic [31:0] ed, input logic [3:0] ec);
    tests++;
    if (ad !== ed || ac !== ec) begin
      fails++;
      $display("FAIL %s: got %h/%b expected %h/%b", req, ad, ac, ed, ec);
    end
  endtask

  function automatic logic [7:0] gap_code(input int g);
    if (g == 0)           return 8'hBC;
    else if (g % 16 == 0) return 8'h7C;
    else if (g % 2 == 1)  return 8'h1C;
    else                  return 8'hBC;
  endfunction

  // drive one column; check the column driven one step earlier
  task automatic step(input logic en, input logic [31:0] d, input logic [3:0] c, input string req);
    bit full;
    bit term;
    @(negedge clk);
    if (has_prev) check(exp_req, tx_data_o, tx_ctrl_o, exp_d, exp_c);
    xcvr_en = en; tx_data_i = d; tx_ctrl_i = c;
    full = 1; term = 0;
    for (int i = 0; i < 4; i++) begin
      if (!(c[i] && d[8*i +: 8] == 8'h07)) full = 0;
      if (c[i] && d[8*i +: 8] == 8'hFD) term = 1;
    end
    exp_d = d; exp_c = c;
    if (en) begin
      if (term) begin
        for (int i = 0; i < 4; i++)
          if (c[i] && d[8*i +: 8] == 8'h07) exp_d[8*i +: 8] = 8'hBC;
        gidx = 0;
      end else if (full) begin
        exp_d = {4{gap_code(gidx)}};
        exp_c = 4'hF;
        gidx++;
      end
    end
    exp_req = req;
    has_prev = 1;
  endtask

  initial begin
    #(20ns * 200000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  c;
    tx_data_i = IDLE4; tx_ctrl_i = 4'hF; xcvr_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", tx_data_o, tx_ctrl_o, 32'h0, 4'h0);
    rst_n = 1'b1;
    tx_data_i = 32'h0; tx_ctrl_i = 4'h0;
    @(negedge clk);
    check("R1 after reset", tx_data_o, tx_ctrl_o, 32'h0, 4'h0);

    // R5/R6/R7: gap since reset
    for (int k = 0; k < 3; k++) step(1, IDLE4, 4'hF, "R5 R6 R7 idle after reset");
    // R2: data and start
    step(1, 32'h44332211, 4'h0, "R2 data");
    step(1, 32'h030201FB, 4'h1, "R2 start lane0");
    step(1, 32'hA5FE5A01, 4'h4, "R2 other control");

    // R4/R6: terminate on each lane, then long gap
    for (int t = 0; t < 4; t++) begin
      d = 32'h0; c = 4'h0;
      for (int i = 0; i < 4; i++) begin
        if (i < t) d[8*i +: 8] = 8'h10 + 8'(i);
        else if (i == t) begin d[8*i +: 8] = 8'hFD; c[i] = 1'b1; end
        else begin d[8*i +: 8] = 8'h07; c[i] = 1'b1; end
      end
      step(1, 32'h66778899, 4'h0, "R2 data before end");
      step(1, d, c, "R4 terminate column");
      for (int k = 0; k < 36; k++) step(1, IDLE4, 4'hF, "R6 R7 gap schedule");
    end

    // R8: partial idles with no terminate
    step(1, 32'h07075566, 4'hC, "R8 partial idle");
    step(1, 32'h07070707, 4'h7, "R8 idle bytes lane3 data");

    // R9: data between idle columns keeps numbering
    step(1, 32'h00000000, 4'h0, "R2 data");
    step(1, {8'h07, 8'h07, 8'hFD, 8'h01}, 4'hE, "R4 terminate lane1");
    step(1, IDLE4, 4'hF, "R5 first after term");
    step(1, IDLE4, 4'hF, "R6 g1");
    step(1, 32'hDEADBEEF, 4'h0, "R9 data inside gap");
    step(1, IDLE4, 4'hF, "R9 numbering continues");
    step(1, IDLE4, 4'hF, "R9 numbering continues");

    // R3: mode off passes through and holds state
    step(0, {8'h07, 8'hFD, 8'h12, 8'h34}, 4'hC, "R3 term passthrough");
    for (int k = 0; k < 3; k++) step(0, IDLE4, 4'hF, "R3 idle passthrough");
    step(0, 32'hCAFEF00D, 4'h0, "R3 data passthrough");
    for (int k = 0; k < 20; k++) step(1, IDLE4, 4'hF, "R3 R6 state held");

    step(1, 32'h0, 4'h0, "R2 flush");
    @(negedge clk);
    check(exp_req, tx_data_o, tx_ctrl_o, exp_d, exp_c);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule